// File: doc/BRIEF.md
# Lockable Crossbar Port Configuration Registers

This block is the register file that configures a bus crossbar's slave-side arbiters. Four slave ports are implemented: 2, 3, 6 and 7. Each of them has two registers. The priority word gives every master's rank when the port's arbiter runs in fixed-priority mode. In round-robin mode the arbiter ignores it, except when more than one master has been marked high priority. The control word holds general-purpose settings for the port, and its top bit is a write-once lock. One further general-purpose word belongs to master port 7. The block drives every register value out as a flat vector that the arbiters consume directly.

Software reaches the registers over a simple request/response bus. A request is taken when `req_valid` and `req_ready` are both high. Exactly one cycle later the block raises `rsp_valid` for one cycle, together with the registered read data and the error flag. The response machine has two states:
- `ST_IDLE` is the state after reset. It holds `req_ready` high and moves to `ST_RESP` when `req_valid` is seen; otherwise it stays.
- `ST_RESP` drives `rsp_valid` high and `req_ready` low, and always returns to `ST_IDLE` on the next cycle.

An access is refused with an error, and changes nothing, in any of these cases: it does not come from supervisor mode, it is narrower than a full word, it targets a reserved offset, or it writes to a locked port.

Top module: `xbar_cfg_regs`

## Requirements
- R1: After reset, every slave priority word reads 0x5400_3210. Every slave control word and the master word read 0x0000_0000.
- R2: For slave port n in {2,3,6,7}, the priority word is at offset n*0x100 and the control word is at n*0x100+0x10. Both are read and written at those offsets, and `prio_o`/`ctrl_o` slice k (k = 0..3 for ports 2,3,6,7) shows the stored value.
- R3: An access with `req_super` low gets an error response, reads as zero and changes no register.
- R4: `req_size` encodes 0 for byte, 1 for halfword and 2 for word. Any access that is not a word gets an error response and changes no register.
- R5: Writing a control word with bit 31 set locks that port. From then on, any write to either register of that port gets an error and leaves both registers unchanged. Other ports are not affected.
- R6: The registers of a locked port can still be read without an error.
- R7: Once the lock bit is set, only reset clears it. A write of zero to a locked control word leaves bit 31 set.
- R8: A request accepted in one cycle produces `rsp_valid` high in the next cycle. `req_ready` is low while `rsp_valid` is high.
- R9: The master general-purpose word is at offset 0xF00 and can be read and written there.
- R10: Every offset not named in R2 or R9 is reserved: an access there gets an error, and any error response carries all-zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| req_super | input | 1 | Supervisor-mode access |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | 32 | Read data (zero on error) |
| rsp_err | output | 1 | Error response |
| prio_o | output | 128 | Priority words of ports 2,3,6,7 (slice 0 = port 2) |
| ctrl_o | output | 128 | Control words of ports 2,3,6,7 (slice 0 = port 2) |
| mgp_o | output | 32 | Master port 7 general-purpose word |

## Verification
The properties assume that `req_valid` and the other request fields hold no X once reset is released. They also assume that a requester keeps its fields stable only for the cycle in which the request is taken. The lock properties assume that register contents move only through accepted, error-free writes. The bench drives all inputs on the falling edge and raises `req_valid` only while the block is idle. It always drops `req_valid` in the cycle in which the response is sampled, so no request overlaps `ST_RESP`.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    localparam int unsigned NUM_PORTS = 4;
    localparam int unsigned LOCK_BIT  = 31;
    localparam logic [31:0] PRIO_INIT = 32'h5400_3210;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rsp_state_e;

    // Physical slave port number of each implemented slot
    function automatic int unsigned slot_port(input int unsigned slot);
        case (slot)
            0:       return 2;
            1:       return 3;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned AW      = 14,
    parameter int unsigned NP      = 4,
    parameter int unsigned MGP_OFS = 'hF00
) (
    input  logic [AW-1:0] addr,
    output logic [NP-1:0] sel_prio,
    output logic [NP-1:0] sel_ctrl,
    output logic          sel_mgp,
    output logic          hit
);

    localparam int unsigned PORT_STRIDE = 'h100;
    localparam int unsigned CTRL_OFS    = 'h10;

    always_comb begin
        sel_prio = '0;
        sel_ctrl = '0;
        for (int unsigned i = 0; i < NP; i++) begin
            sel_prio[i] = (addr == AW'(slot_port(i) * PORT_STRIDE));
            sel_ctrl[i] = (addr == AW'(slot_port(i) * PORT_STRIDE + CTRL_OFS));
        end
        sel_mgp = (addr == AW'(MGP_OFS));
        hit     = (|sel_prio) | (|sel_ctrl) | sel_mgp;
    end

endmodule

// File: rtl/xbar_cfg_port.sv
module xbar_cfg_port #(
    parameter int unsigned    DW        = 32,
    parameter int unsigned    LOCK_POS  = 31,
    parameter logic [DW-1:0]  PRIO_RST  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_prio,
    input  logic          we_ctrl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] prio_q,
    output logic [DW-1:0] ctrl_q,
    output logic          locked
);

    assign locked = ctrl_q[LOCK_POS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= PRIO_RST;
            ctrl_q <= '0;
        end else if (!locked) begin
            if (we_prio) prio_q <= wdata;
            if (we_ctrl) ctrl_q <= wdata;
        end
    end

endmodule

// File: rtl/xbar_cfg_fsm.sv
module xbar_cfg_fsm
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          err_in,
    input  logic [DW-1:0] rdata_in,
    output logic          req_ready,
    output logic          accept,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err
);

    rsp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        accept    = req_ready && req_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else if (accept) begin
            rsp_rdata <= err_in ? '0 : rdata_in;
            rsp_err   <= err_in;
        end
    end

endmodule

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_cfg_pkg::*;
#(
    parameter int unsigned AW      = 14,
    parameter int unsigned DW      = 32,
    parameter int unsigned MGP_OFS = 'hF00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    input  logic [1:0]               req_size,
    input  logic                     req_super,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_rdata,
    output logic                     rsp_err,
    output logic [NUM_PORTS*DW-1:0]  prio_o,
    output logic [NUM_PORTS*DW-1:0]  ctrl_o,
    output logic [DW-1:0]            mgp_o
);

    localparam int unsigned NP = NUM_PORTS;

    logic [NP-1:0] sel_prio, sel_ctrl, port_lock;
    logic          sel_mgp, hit, accept, acc_bad, wr_ok, lock_hit;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] prio_q [NP];
    logic [DW-1:0] ctrl_q [NP];
    logic [DW-1:0] mgp_q;

    xbar_cfg_decode #(.AW(AW), .NP(NP), .MGP_OFS(MGP_OFS)) dec_i (
        .addr     (req_addr),
        .sel_prio (sel_prio),
        .sel_ctrl (sel_ctrl),
        .sel_mgp  (sel_mgp),
        .hit      (hit)
    );

    always_comb begin
        lock_hit = |((sel_prio | sel_ctrl) & port_lock);
        acc_bad  = !req_super || (req_size != SZ_WORD) || !hit || (req_write && lock_hit);
        wr_ok    = accept && req_write && !acc_bad;
        rd_mux   = '0;
        for (int unsigned i = 0; i < NP; i++) begin
            if (sel_prio[i]) rd_mux = rd_mux | prio_q[i];
            if (sel_ctrl[i]) rd_mux = rd_mux | ctrl_q[i];
        end
        if (sel_mgp) rd_mux = rd_mux | mgp_q;
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        xbar_cfg_port #(.DW(DW), .LOCK_POS(LOCK_BIT), .PRIO_RST(DW'(PRIO_INIT))) port_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_prio (wr_ok && sel_prio[g]),
            .we_ctrl (wr_ok && sel_ctrl[g]),
            .wdata   (req_wdata),
            .prio_q  (prio_q[g]),
            .ctrl_q  (ctrl_q[g]),
            .locked  (port_lock[g])
        );
        assign prio_o[g*DW +: DW] = prio_q[g];
        assign ctrl_o[g*DW +: DW] = ctrl_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               mgp_q <= '0;
        else if (wr_ok && sel_mgp) mgp_q <= req_wdata;
    end
    assign mgp_o = mgp_q;

    xbar_cfg_fsm #(.DW(DW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .err_in    (acc_bad),
        .rdata_in  (rd_mux),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
    parameter int unsigned NP   = 4,
    parameter int unsigned DW   = 32,
    parameter int unsigned LOCK = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_super,
    input logic [1:0]      req_size,
    input logic            rsp_valid,
    input logic [DW-1:0]   rsp_rdata,
    input logic            rsp_err,
    input logic [NP*DW-1:0] prio_o,
    input logic [NP*DW-1:0] ctrl_o,
    input logic [DW-1:0]   mgp_o
);

    // R8
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R8
    no_ready_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R3
    user_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_super) |=>
            (rsp_err && $stable(prio_o) && $stable(ctrl_o) && $stable(mgp_o)));

    // R4
    narrow_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size != 2'd2) |=>
            (rsp_err && $stable(prio_o) && $stable(ctrl_o) && $stable(mgp_o)));

    for (genvar g = 0; g < NP; g++) begin : g_lock
        // R5
        locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_o[g*DW+LOCK] |=> ($stable(prio_o[g*DW +: DW]) && $stable(ctrl_o[g*DW +: DW])));
        // R7
        lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_o[g*DW+LOCK] |=> ctrl_o[g*DW+LOCK]);
    end

endmodule

bind xbar_cfg_regs xbar_cfg_chk #(.NP(NUM_PORTS), .DW(DW), .LOCK(LOCK_BIT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_super (req_super),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .prio_o    (prio_o),
    .ctrl_o    (ctrl_o),
    .mgp_o     (mgp_o)
);

// File: tb/xbar_cfg_regs_tb_top.sv
module xbar_cfg_regs_tb_top;

    localparam int unsigned AW = 14;
    localparam int unsigned DW = 32;
    localparam logic [31:0] PRIO_RST = 32'h5400_3210;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] req_size = 2'd0;
    logic req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata, mgp_o;
    logic [4*DW-1:0] prio_o, ctrl_o;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    xbar_cfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_size(req_size), .req_super(req_super), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .prio_o(prio_o),
        .ctrl_o(ctrl_o), .mgp_o(mgp_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [1:0] sz, input bit sup,
                          output logic [31:0] rd, output logic er);
        @(negedge clk);
        check(req_ready === 1'b1, "R8 ready in idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_size = sz; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R8 rsp one cycle later", {31'b0, rsp_valid}, 32'd1);
        check(req_ready === 1'b0, "R8 not ready in rsp", {31'b0, req_ready}, 32'd0);
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic er;
        for (int k = 0; k < 4; k++) begin
            check(prio_o[k*32 +: 32] === PRIO_RST, "R1 prio reset", prio_o[k*32 +: 32], PRIO_RST);
            check(ctrl_o[k*32 +: 32] === 32'h0, "R1 ctrl reset", ctrl_o[k*32 +: 32], 32'h0);
        end
        check(mgp_o === 32'h0, "R1 mgp reset", mgp_o, 32'h0);
        access(1'b0, 14'h700, 0, 2'd2, 1'b1, rd, er);
        check(rd === PRIO_RST && !er, "R1 prio read at reset", rd, PRIO_RST);
    endtask

    task automatic t_rw();
        logic [31:0] rd; logic er;
        access(1'b1, 14'h300, 32'h0000_1023, 2'd2, 1'b1, rd, er);
        check(!er, "R2 write ok", {31'b0, er}, 0);
        access(1'b0, 14'h300, 0, 2'd2, 1'b1, rd, er);
        check(rd === 32'h0000_1023, "R2 prio3 readback", rd, 32'h0000_1023);
        check(prio_o[32 +: 32] === 32'h0000_1023, "R2 prio3 output", prio_o[32 +: 32], 32'h0000_1023);
        access(1'b1, 14'h610, 32'h0000_0005, 2'd2, 1'b1, rd, er);
        access(1'b0, 14'h610, 0, 2'd2, 1'b1, rd, er);
        check(rd === 32'h5 && !er, "R2 ctrl6 readback", rd, 32'h5);
        check(ctrl_o[64 +: 32] === 32'h5, "R2 ctrl6 output", ctrl_o[64 +: 32], 32'h5);
    endtask

    task automatic t_mgp();
        logic [31:0] rd; logic er;
        access(1'b1, 14'hF00, 32'hA5A5_0F0F, 2'd2, 1'b1, rd, er);
        access(1'b0, 14'hF00, 0, 2'd2, 1'b1, rd, er);
        check(rd === 32'hA5A5_0F0F && !er, "R9 master word readback", rd, 32'hA5A5_0F0F);
        check(mgp_o === 32'hA5A5_0F0F, "R9 master output", mgp_o, 32'hA5A5_0F0F);
    endtask

    task automatic t_reserved();
        logic [31:0] rd; logic er;
        access(1'b0, 14'h100, 0, 2'd2, 1'b1, rd, er);
        check(er === 1'b1 && rd === 0, "R10 unimplemented port 1", rd, 0);
        access(1'b0, 14'h204, 0, 2'd2, 1'b1, rd, er);
        check(er === 1'b1 && rd === 0, "R10 gap offset", rd, 0);
        access(1'b1, 14'h3FFC, 32'hFFFF_FFFF, 2'd2, 1'b1, rd, er);
        check(er === 1'b1, "R10 write reserved err", {31'b0, er}, 1);
    endtask

    task automatic t_mode();
        logic [31:0] rd; logic er;
        access(1'b1, 14'h700, 32'h1111_1111, 2'd2, 1'b0, rd, er);
        check(er === 1'b1, "R3 user write err", {31'b0, er}, 1);
        access(1'b0, 14'h700, 0, 2'd2, 1'b0, rd, er);
        check(er === 1'b1 && rd === 0, "R3 user read zero", rd, 0);
        check(prio_o[96 +: 32] === PRIO_RST, "R3 user write no effect", prio_o[96 +: 32], PRIO_RST);
    endtask

    task automatic t_size();
        logic [31:0] rd; logic er;
        access(1'b1, 14'h710, 32'h0000_00FF, 2'd1, 1'b1, rd, er);
        check(er === 1'b1, "R4 halfword err", {31'b0, er}, 1);
        access(1'b1, 14'h710, 32'h0000_00FF, 2'd0, 1'b1, rd, er);
        check(er === 1'b1, "R4 byte err", {31'b0, er}, 1);
        access(1'b0, 14'h710, 0, 2'd2, 1'b1, rd, er);
        check(rd === 0 && !er, "R4 narrow write no effect", rd, 0);
    endtask

    task automatic t_lock();
        logic [31:0] rd; logic er;
        access(1'b1, 14'h210, 32'h8000_0001, 2'd2, 1'b1, rd, er);
        check(!er, "R5 lock write accepted", {31'b0, er}, 0);
        access(1'b1, 14'h200, 32'h0000_0000, 2'd2, 1'b1, rd, er);
        check(er === 1'b1, "R5 locked prio write err", {31'b0, er}, 1);
        access(1'b0, 14'h200, 0, 2'd2, 1'b1, rd, er);
        check(rd === PRIO_RST && !er, "R6 locked prio readable", rd, PRIO_RST);
        access(1'b1, 14'h210, 32'h0, 2'd2, 1'b1, rd, er);
        check(er === 1'b1, "R7 unlock attempt err", {31'b0, er}, 1);
        access(1'b0, 14'h210, 0, 2'd2, 1'b1, rd, er);
        check(rd === 32'h8000_0001 && !er, "R7 lock stays set", rd, 32'h8000_0001);
        access(1'b1, 14'h310, 32'h0000_0002, 2'd2, 1'b1, rd, er);
        check(!er && ctrl_o[32 +: 32] === 32'h2, "R5 other port unaffected", ctrl_o[32 +: 32], 32'h2);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_mgp();
        t_reserved();
        t_mode();
        t_size();
        t_lock();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule